// File: doc/BRIEF.md
# Scan Access Key Lock Controller

This block decides, once per reset, whether the party driving a scan test is trusted. It watches the test-control input and the serial scan-in stream. From the first scan pattern after reset it takes a leading key field and compares it bit by bit with a key stored as a parameter. The result is latched into a mode flag: secure when the key matched, insecure otherwise. After the key field comes a seed field. On a match, the block raises a load strobe while those seed bits pass, so a separate subchain selector can shift them into its seed. On a mismatch the seed bits are ignored. Instead, the block asks the selector to reseed from a random value, which it samples from an external random-source input.

Only when both the key field and the seed field have gone by does the block route scan-in to the scan subchains. The key and seed fields are consumed only once per reset. Every later test-control assertion goes straight to pattern shifting. In insecure mode, every new scan round begins with a fresh random reseed request. The selector, the scan cells and the random generator sit outside this block.

Top module: `scan_lock_ctrl`

## Requirements
- R1: After reset, secure_mode, seed_load, scan_route and reseed_req are all low.
- R2: Key bits are taken one per clock on the cycles where test_en is high, starting with the first such cycle after reset. Key bit index 0 is taken first (least significant bit first). When all KEY_W bits equal KEY_VAL, secure_mode goes high in the cycle after the last key bit.
- R3: Once secure_mode is high, it stays high until reset, whatever is later shifted in.
- R4: After a matching key, seed_load is high on exactly the first SEED_W cycles with test_en high that follow the last key bit.
- R5: After a mismatching key, secure_mode stays low and seed_load stays low through the SEED_W seed cycles. reseed_req is a one-cycle pulse in the cycle after the last key bit, and reseed_val then equals the rnd_in present on that last key bit.
- R6: scan_route is high only when test_en is high and the key and seed phases are both complete. seed_load and scan_route are never high together.
- R7: Once the phases are complete and the block is insecure, every rising edge of test_en causes a reseed_req pulse in the next cycle. reseed_val then carries the rnd_in present at that rise. In secure mode, reseed_req never rises.
- R8: If test_en drops during the key phase, the attempt counts as a fail and the seed phase is skipped. The next test_en assertion routes scan-in at once and is followed by a reseed_req pulse.
- R9: If test_en goes low during the seed phase, the seed phase pauses. It resumes counting when test_en returns high.
- R10: Reset restarts the whole protocol. The key phase runs again, and a previously secure or failed state is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Scan test control, high while shifting |
| scan_in | input | 1 | Serial scan data input |
| rnd_in | input | SEED_W | Value from the external random source |
| secure_mode | output | 1 | High once a matching key has been seen |
| seed_load | output | 1 | Selector shifts scan_in into its seed this cycle |
| scan_route | output | 1 | scan_in is routed to the subchains this cycle |
| reseed_req | output | 1 | One-cycle request to load reseed_val as seed |
| reseed_val | output | SEED_W | Random seed sampled for the request |

## Verification
The bench drives several patterns:
- The exact key. This separates the pass path from the fail path.
- A key wrong only in its last bit. This shows the mismatch is resolved at the final bit rather than earlier.
- A key wrong only in its first bit. This shows the sticky mismatch flag holds across the remaining bits.
- A key phase cut short by dropping test_en. This exercises the abort path, where the seed phase is skipped.

Gaps in test_en during the seed phase show that counting pauses rather than restarts. Repeated scan rounds after a pass and after a fail show the difference between the silent secure mode and the per-round reseeding of the insecure mode. A second pass after a reset confirms that reset clears the verdict.

// File: rtl/scan_lock_pkg.sv
package scan_lock_pkg;

    typedef enum logic [1:0] {
        PH_ARM  = 2'd0,
        PH_KEY  = 2'd1,
        PH_SEED = 2'd2,
        PH_DONE = 2'd3
    } lock_phase_e;

    typedef struct packed {
        logic seed_load;
        logic scan_route;
        logic reseed_trig;
    } lock_ctl_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int key_w, input int seed_w);
        return $clog2(max_int(key_w, seed_w) + 1);
    endfunction

endpackage

// File: rtl/slk_key_cmp.sv
module slk_key_cmp
    import scan_lock_pkg::*;
#(
    parameter int              KEY_W   = 64,
    parameter logic [KEY_W-1:0] KEY_VAL = 64'hC3E1_5A96_0F4B_72D8,
    parameter int              IDX_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_in,
    output logic             pass_now
);
    logic mism_q;
    logic ref_bit;

    always_comb begin
        ref_bit  = KEY_VAL[bit_idx];
        pass_now = !mism_q && (bit_in == ref_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mism_q <= 1'b0;
        end else if (bit_vld && (bit_in != ref_bit)) begin
            mism_q <= 1'b1;
        end
    end
endmodule

// File: rtl/slk_phase_fsm.sv
module slk_phase_fsm
    import scan_lock_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int SEED_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic             pass_now,
    output logic             key_take,
    output logic [CNT_W-1:0] cnt,
    output logic             secure,
    output lock_ctl_t        ctl
);
    localparam logic [CNT_W-1:0] KEY_LAST  = CNT_W'(KEY_W - 1);
    localparam logic [CNT_W-1:0] SEED_LAST = CNT_W'(SEED_W - 1);

    lock_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             secure_q;
    logic             ten_d_q;
    logic             key_last;
    logic             round_rise;

    always_comb begin
        key_take   = test_en && (phase_q == PH_ARM || phase_q == PH_KEY);
        key_last   = key_take && (cnt_q == KEY_LAST);
        round_rise = (phase_q == PH_DONE) && test_en && !ten_d_q && !secure_q;
        ctl.seed_load   = (phase_q == PH_SEED) && test_en && secure_q;
        ctl.scan_route  = (phase_q == PH_DONE) && test_en;
        ctl.reseed_trig = (key_last && !pass_now) || round_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ARM;
            cnt_q    <= '0;
            secure_q <= 1'b0;
            ten_d_q  <= 1'b0;
        end else begin
            ten_d_q <= test_en;
            unique case (phase_q)
                PH_ARM: begin
                    if (test_en) begin
                        phase_q <= PH_KEY;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                PH_KEY: begin
                    if (!test_en) begin
                        phase_q <= PH_DONE;
                        cnt_q   <= '0;
                    end else if (key_last) begin
                        secure_q <= pass_now;
                        phase_q  <= PH_SEED;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_SEED: begin
                    if (test_en) begin
                        if (cnt_q == SEED_LAST) begin
                            phase_q <= PH_DONE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    phase_q <= PH_DONE;
                end
            endcase
        end
    end

    assign cnt    = cnt_q;
    assign secure = secure_q;
endmodule

// File: rtl/slk_reseed_reg.sv
module slk_reseed_reg #(
    parameter int SEED_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [SEED_W-1:0] rnd_in,
    output logic              req,
    output logic [SEED_W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            val <= '0;
        end else begin
            req <= trig;
            if (trig) begin
                val <= rnd_in;
            end
        end
    end
endmodule

// File: rtl/scan_lock_ctrl.sv
module scan_lock_ctrl
    import scan_lock_pkg::*;
#(
    parameter int               KEY_W   = 64,
    parameter int               SEED_W  = 8,
    parameter logic [KEY_W-1:0] KEY_VAL = 64'hC3E1_5A96_0F4B_72D8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic              scan_in,
    input  logic [SEED_W-1:0] rnd_in,
    output logic              secure_mode,
    output logic              seed_load,
    output logic              scan_route,
    output logic              reseed_req,
    output logic [SEED_W-1:0] reseed_val
);
    localparam int CNT_W = cnt_width(KEY_W, SEED_W);

    logic             key_take;
    logic             pass_now;
    logic [CNT_W-1:0] cnt;
    logic             secure;
    lock_ctl_t        ctl;

    slk_key_cmp #(
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL),
        .IDX_W  (CNT_W)
    ) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (key_take),
        .bit_idx (cnt),
        .bit_in  (scan_in),
        .pass_now(pass_now)
    );

    slk_phase_fsm #(
        .KEY_W (KEY_W),
        .SEED_W(SEED_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .pass_now(pass_now),
        .key_take(key_take),
        .cnt     (cnt),
        .secure  (secure),
        .ctl     (ctl)
    );

    slk_reseed_reg #(
        .SEED_W(SEED_W)
    ) u_rsd (
        .clk   (clk),
        .rst   (rst),
        .trig  (ctl.reseed_trig),
        .rnd_in(rnd_in),
        .req   (reseed_req),
        .val   (reseed_val)
    );

    assign secure_mode = secure;
    assign seed_load   = ctl.seed_load;
    assign scan_route  = ctl.scan_route;
endmodule

// File: rtl/scan_lock_chk.sv
module scan_lock_chk (
    input logic clk,
    input logic rst,
    input logic test_en,
    input logic secure_mode,
    input logic seed_load,
    input logic scan_route,
    input logic reseed_req
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (rst || !seen_q)
        secure_mode |=> secure_mode);

    assert_load_needs_pass_R4: assert property (@(posedge clk) disable iff (rst || !seen_q)
        seed_load |-> (secure_mode && test_en));

    assert_route_exclusive_R6: assert property (@(posedge clk) disable iff (rst || !seen_q)
        scan_route |-> (test_en && !seed_load));

    assert_reseed_pulse_R5: assert property (@(posedge clk) disable iff (rst || !seen_q)
        reseed_req |=> !reseed_req);

    assert_secure_quiet_R7: assert property (@(posedge clk) disable iff (rst || !seen_q)
        secure_mode |-> !reseed_req);

    assert_pass_on_shift_R2: assert property (@(posedge clk) disable iff (rst || !seen_q)
        $rose(secure_mode) |-> $past(test_en));
endmodule

bind scan_lock_ctrl scan_lock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .test_en    (test_en),
    .secure_mode(secure_mode),
    .seed_load  (seed_load),
    .scan_route (scan_route),
    .reseed_req (reseed_req)
);

// File: tb/tb_scan_lock_ctrl.sv
module tb_scan_lock_ctrl;
    localparam int KW = 64;
    localparam int SW = 8;
    localparam logic [KW-1:0] TB_KEY = 64'hC3E1_5A96_0F4B_72D8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          test_en = 1'b0;
    logic          scan_in = 1'b0;
    logic [SW-1:0] rnd_in = '0;
    logic          secure_mode, seed_load, scan_route, reseed_req;
    logic [SW-1:0] reseed_val;

    scan_lock_ctrl #(.KEY_W(KW), .SEED_W(SW), .KEY_VAL(TB_KEY)) dut (
        .clk(clk), .rst(rst), .test_en(test_en), .scan_in(scan_in), .rnd_in(rnd_in),
        .secure_mode(secure_mode), .seed_load(seed_load), .scan_route(scan_route),
        .reseed_req(reseed_req), .reseed_val(reseed_val)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural expectation: 0 = waiting for first test, 1 = key, 2 = seed, 3 = free shifting
    int            m_phase;
    int            m_n;
    bit            m_mis;
    bit            m_sec;
    bit            m_rq;
    logic [SW-1:0] m_rv;
    bit            m_prev;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_phase = 0; m_n = 0; m_mis = 0; m_sec = 0; m_rq = 0; m_rv = '0; m_prev = 0;
    endtask

    task automatic step(input string ctx, input logic ten, input logic si);
        logic [SW-1:0] rnd;
        bit            n_rq;
        rnd = SW'($urandom);
        @(negedge clk);
        test_en = ten; scan_in = si; rnd_in = rnd;
        #1;
        chk({ctx, " R3 secure_mode"}, 64'(secure_mode), 64'(m_sec));
        chk({ctx, " R7 reseed_req"}, 64'(reseed_req), 64'(m_rq));
        if (m_rq) chk({ctx, " R5 reseed_val"}, 64'(reseed_val), 64'(m_rv));
        chk({ctx, " R4 seed_load"}, 64'(seed_load), 64'(m_phase == 2 && ten && m_sec));
        chk({ctx, " R6 scan_route"}, 64'(scan_route), 64'(m_phase == 3 && ten));
        n_rq = 0;
        if (m_phase == 0) begin
            if (ten) begin
                m_mis = (si != TB_KEY[0]); m_n = 1; m_phase = 1;
            end
        end else if (m_phase == 1) begin
            if (!ten) m_phase = 3;
            else begin
                if (si != TB_KEY[m_n]) m_mis = 1;
                if (m_n == KW - 1) begin
                    m_sec = !m_mis;
                    if (m_mis) begin n_rq = 1; m_rv = rnd; end
                    m_phase = 2; m_n = 0;
                end else m_n++;
            end
        end else if (m_phase == 2) begin
            if (ten) begin
                m_n++;
                if (m_n == SW) begin m_phase = 3; m_n = 0; end
            end
        end else begin
            if (ten && !m_prev && !m_sec) begin n_rq = 1; m_rv = rnd; end
        end
        m_rq = n_rq;
        m_prev = ten;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; test_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_clear();
        #1;
        // R1: outputs quiet after reset
        chk("R1 secure_mode", 64'(secure_mode), 64'd0);
        chk("R1 seed_load", 64'(seed_load), 64'd0);
        chk("R1 scan_route", 64'(scan_route), 64'd0);
        chk("R1 reseed_req", 64'(reseed_req), 64'd0);
    endtask

    task automatic send_key(input string ctx, input logic [KW-1:0] k);
        for (int i = 0; i < KW; i++) step(ctx, 1'b1, k[i]);
    endtask

    task automatic run(input string ctx, input logic ten, input int n);
        for (int i = 0; i < n; i++) step(ctx, ten, 1'($urandom));
    endtask

    initial begin
        model_clear();
        do_reset();
        run("R1 idle", 1'b0, 5);

        // R2: exact key, least significant bit first
        send_key("R2 good key", TB_KEY);
        step("R2 verdict", 1'b1, 1'b1);
        chk("R2 secure after key", 64'(secure_mode), 64'd1);
        // R9: seed phase paused by gaps in test_en
        run("R9 seed", 1'b1, 3);
        run("R9 pause", 1'b0, 4);
        run("R9 seed resume", 1'b1, 4);
        run("R6 shift", 1'b1, 20);
        run("R7 gap", 1'b0, 3);
        run("R7 round", 1'b1, 10);
        // R3: a wrong key later has no effect
        send_key("R3 late bad key", ~TB_KEY);
        run("R3 gap", 1'b0, 2);
        chk("R3 still secure", 64'(secure_mode), 64'd1);

        // R5: key wrong only in its last bit
        do_reset();
        send_key("R5 bad last bit", TB_KEY ^ (64'd1 << (KW - 1)));
        run("R5 seed ignored", 1'b1, SW);
        chk("R5 insecure", 64'(secure_mode), 64'd0);
        run("R6 shift", 1'b1, 12);
        for (int r = 0; r < 4; r++) begin
            run("R7 gap", 1'b0, 2 + r);
            run("R7 round", 1'b1, 6);
        end

        // R5: key wrong only in its first bit
        do_reset();
        send_key("R5 bad first bit", TB_KEY ^ 64'd1);
        run("R5 seed", 1'b1, SW + 5);
        run("R5 gap", 1'b0, 2);
        run("R7 round", 1'b1, 4);

        // R8: abort during the key phase
        do_reset();
        for (int i = 0; i < 10; i++) step("R8 partial key", 1'b1, TB_KEY[i]);
        run("R8 abort", 1'b0, 3);
        step("R8 resume", 1'b1, 1'b0);
        chk("R8 routed at once", 64'(scan_route), 64'd1);
        run("R8 shift", 1'b1, 8);
        chk("R8 insecure", 64'(secure_mode), 64'd0);

        // R10: reset restarts the protocol and a good key passes again
        do_reset();
        run("R10 idle", 1'b0, 2);
        send_key("R10 good key", TB_KEY);
        run("R10 seed", 1'b1, SW);
        run("R10 shift", 1'b1, 6);
        chk("R10 secure again", 64'(secure_mode), 64'd1);
        run("R10 tail", 1'b0, 3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule